// File: doc/BRIEF.md
# Privileged interrupt level mask

This block holds the 4-bit interrupt masking level of a CPU core. The level is written `{P, ILM}`. P is a privilege bit that sits above a 3-bit mask field. With P=0 the level is privileged and has high priority. With P=1 it is a user level with lower priority. Within each group, a smaller number means higher priority, and the whole 4-bit value is compared as an unsigned number.

Each cycle the block looks at one pending interrupt request and at one software write to the mask. A request is taken when its level is numerically below the current mask. When a request is taken, its level becomes the new mask, so requests of equal or lower priority are blocked until software lowers the mask again.

Only special sources may reach a privileged level through a request. These sources are a non-maskable interrupt, hardware interrupt 9 and the debug unit. Software writes are filtered: while the mask is privileged, software may only raise the mask number or move into user levels. Both results are registered and appear one clock after the inputs are sampled.

Top module: `prio_mask_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `level_out` is 4'b0100 (P=0, ILM=4), and `irq_accept` and `wr_reject` are low.
- R2: A request with `irq_valid`=1 is accepted only if `irq_level`, read as an unsigned 4-bit value, is strictly less than `level_out`. An accepted request raises `irq_accept` for exactly one cycle, in the cycle after it was sampled.
- R3: In the same cycle that `irq_accept` goes high, `level_out` equals the `irq_level` of the accepted request.
- R4: A request with `irq_special`=0 and `irq_level[3]`=0 is never accepted. A request with `irq_special`=1 is judged by the R2 comparison alone.
- R5: An allowed software write loads `{wr_p, wr_imm[2:0]}` into `level_out` in the next cycle. Bits 7..3 of `wr_imm` have no effect.
- R6: When `level_out[3]`=1, every software write is allowed.
- R7: When `level_out[3]`=0, a write is allowed only if `wr_p`=1, or if `wr_imm[2:0]` is strictly greater than `level_out[2:0]`. A refused write leaves `level_out` unchanged and raises `wr_reject` for one cycle, in the next cycle.
- R8: If a request is accepted in the same cycle as a software write, the write is discarded. In that case `level_out` takes the request level and `wr_reject` stays low. If the request is not accepted, the write is handled as R5 to R7 describe.

Once the block is out of reset, `irq_accept` and `wr_reject` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | A request is pending this cycle |
| irq_level | input | 4 | Level of the pending request, {P, ILM} |
| irq_special | input | 1 | The request comes from the non-maskable interrupt, hardware interrupt 9 or the debug unit |
| wr_en | input | 1 | Software writes the mask this cycle |
| wr_imm | input | 8 | Immediate value of the write; only the low 3 bits are used |
| wr_p | input | 1 | New privilege bit of the write |
| irq_accept | output | 1 | One-cycle pulse: a request was taken |
| level_out | output | 4 | Current mask {P, ILM} |
| wr_reject | output | 1 | One-cycle pulse: a write was refused |

## Verification
A wrong stored level shows at the ports in the next cycle. It appears either directly on `level_out` or as a request taken or refused against the wrong threshold, because every decision compares against the stored value. A privilege filter that is too loose lets software move a privileged level downward. That shows on `level_out` one cycle after the write, with no `wr_reject` pulse. The reference model follows the mask on every cycle, so a wrong value is caught at the first edge where it differs from the model.

// File: rtl/prio_mask_pkg.sv
package prio_mask_pkg;

    parameter int ILM_W = 3;
    localparam int LVL_W = ILM_W + 1;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t lvl;
        logic acc;
        logic rej;
    } mask_state_t;

    localparam lvl_t RESET_LVL = lvl_t'(4);

endpackage

// File: rtl/prio_mask_gate.sv
module prio_mask_gate
    import prio_mask_pkg::*;
(
    input  logic req_valid,
    input  lvl_t req_lvl,
    input  logic req_special,
    input  lvl_t cur_lvl,
    output logic take
);
    logic beats_mask;
    logic src_may_enter;

    always_comb begin
        beats_mask    = (req_lvl < cur_lvl);
        // Only special sources may land in a privileged level.
        src_may_enter = req_special || req_lvl[LVL_W-1];
        take          = req_valid && beats_mask && src_may_enter;
    end
endmodule

// File: rtl/prio_mask_wfilter.sv
module prio_mask_wfilter
    import prio_mask_pkg::*;
#(
    parameter int IMM_W = 8
) (
    input  logic             wr_en,
    input  logic [IMM_W-1:0] wr_imm,
    input  logic             wr_p,
    input  lvl_t             cur_lvl,
    output lvl_t             new_lvl,
    output logic             wr_ok,
    output logic             wr_bad
);
    logic             cur_user;
    logic             raises;
    logic [ILM_W-1:0] new_ilm;
    logic             unused_imm_hi;

    always_comb begin
        new_ilm       = wr_imm[ILM_W-1:0];
        unused_imm_hi = ^wr_imm[IMM_W-1:ILM_W];
        new_lvl       = {wr_p, new_ilm};
        cur_user      = cur_lvl[LVL_W-1];
        raises        = (new_ilm > cur_lvl[ILM_W-1:0]);
        wr_ok         = wr_en && (cur_user || wr_p || raises);
        wr_bad        = wr_en && !wr_ok;
    end
endmodule

// File: rtl/prio_mask_ctrl.sv
module prio_mask_ctrl
    import prio_mask_pkg::*;
#(
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_valid,
    input  logic [3:0]       irq_level,
    input  logic             irq_special,
    input  logic             wr_en,
    input  logic [IMM_W-1:0] wr_imm,
    input  logic             wr_p,
    output logic             irq_accept,
    output logic [3:0]       level_out,
    output logic             wr_reject
);
    mask_state_t st_q, st_d;
    logic take_irq;
    lvl_t wr_lvl;
    logic wr_ok, wr_bad;

    prio_mask_gate u_gate (
        .req_valid  (irq_valid),
        .req_lvl    (irq_level),
        .req_special(irq_special),
        .cur_lvl    (st_q.lvl),
        .take       (take_irq)
    );

    prio_mask_wfilter #(.IMM_W(IMM_W)) u_wfilter (
        .wr_en  (wr_en),
        .wr_imm (wr_imm),
        .wr_p   (wr_p),
        .cur_lvl(st_q.lvl),
        .new_lvl(wr_lvl),
        .wr_ok  (wr_ok),
        .wr_bad (wr_bad)
    );

    always_comb begin
        st_d     = st_q;
        st_d.acc = 1'b0;
        st_d.rej = 1'b0;
        if (take_irq) begin
            st_d.lvl = irq_level;
            st_d.acc = 1'b1;
        end else if (wr_ok) begin
            st_d.lvl = wr_lvl;
        end else if (wr_bad) begin
            st_d.rej = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lvl: RESET_LVL, acc: 1'b0, rej: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_accept = st_q.acc;
    assign level_out  = st_q.lvl;
    assign wr_reject  = st_q.rej;

    // R2
    accept_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> ($past(irq_level) < $past(level_out)));

    // R3
    accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (level_out == $past(irq_level)));

    // R4
    nonspecial_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && !$past(irq_special)) |-> $past(irq_level[3]));

    // R7
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $stable(level_out));

    // R7
    priv_no_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_accept && !level_out[3] && !$past(level_out[3]))
            |-> (level_out[2:0] >= $past(level_out[2:0])));

    // R8
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_accept && wr_reject));
endmodule

// File: tb/prio_mask_ctrl_bench.sv
module prio_mask_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_valid = 1'b0;
    logic [3:0] irq_level = '0;
    logic       irq_special = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_imm = '0;
    logic       wr_p = 1'b0;
    logic       irq_accept;
    logic [3:0] level_out;
    logic       wr_reject;

    int checks = 0;
    int fails  = 0;
    int m_lvl  = 4;
    bit m_acc  = 0;
    bit m_rej  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_mask_ctrl u_prio_mask_ctrl (
        .clk(clk), .rst_n(rst_n),
        .irq_valid(irq_valid), .irq_level(irq_level), .irq_special(irq_special),
        .wr_en(wr_en), .wr_imm(wr_imm), .wr_p(wr_p),
        .irq_accept(irq_accept), .level_out(level_out), .wr_reject(wr_reject)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        chk({tag, " R3 level_out"}, int'(level_out), m_lvl);
        chk({tag, " R2 irq_accept"}, int'(irq_accept), int'(m_acc));
        chk({tag, " R7 wr_reject"}, int'(wr_reject), int'(m_rej));
    endtask

    task automatic step(string tag, bit v, int lvl, bit sp, bit we, int imm, bit p);
        int  cur = m_lvl;
        int  ilm_new = imm % 8;
        bit  take;
        take = v && (lvl < cur) && (sp || lvl >= 8);
        m_acc = 0;
        m_rej = 0;
        if (take) begin
            m_lvl = lvl;
            m_acc = 1;
        end else if (we) begin
            if (cur >= 8 || p || ilm_new > (cur % 8)) m_lvl = (p ? 8 : 0) + ilm_new;
            else m_rej = 1;
        end
        irq_valid = v; irq_level = 4'(lvl); irq_special = sp;
        wr_en = we; wr_imm = 8'(imm); wr_p = p;
        @(posedge clk);
        @(negedge clk);
        irq_valid = 0; wr_en = 0;
        compare_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        compare_all("R1 after release");

        step("R4 plain req to priv", 1, 2, 0, 0, 0, 0);
        step("R4 special req to priv", 1, 2, 1, 0, 0, 0);
        step("R2 lower prio req", 1, 3, 1, 0, 0, 0);
        step("R2 equal req", 1, 2, 1, 0, 0, 0);
        step("R7 priv lower write", 0, 0, 0, 1, 8'hF9, 0);
        step("R5 priv raise high bits", 0, 0, 0, 1, 8'hA5, 0);
        step("R7 priv same write", 0, 0, 0, 1, 8'h05, 0);
        step("R7 priv to user", 0, 0, 0, 1, 8'h00, 1);
        step("R2 equal user req", 1, 8, 0, 0, 0, 0);
        step("R6 user write", 0, 0, 0, 1, 8'hFF, 1);
        step("R2 user req", 1, 11, 0, 0, 0, 0);
        step("R6 user to priv0", 0, 0, 0, 1, 8'h00, 0);
        step("R6 back to user", 0, 0, 0, 1, 8'h03, 1);
        step("R8 accept beats write", 1, 9, 0, 1, 8'h07, 1);
        step("R8 write after refused req", 1, 12, 0, 1, 8'h02, 1);
        step("R8 refused write with accept", 1, 1, 1, 1, 8'h00, 0);
        step("R7 refused after accept", 0, 0, 0, 1, 8'h00, 0);

        for (int i = 0; i < 4000; i++) begin
            step("rand", $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule